// File: doc/BRIEF.md
# Two-Round SHA-256 Compression Step

This block advances a SHA-256 working state by exactly two compression rounds in one operation. The eight working words arrive split across two 128-bit packed operands. One operand holds the words that the step rewrites (A, B, E, F). The other holds the words that only shift (C, D, G, H). A third 128-bit operand carries the sums of message word and round constant for the two rounds, added beforehand. The block returns a packed 128-bit word with the new A, B, E and F. Message expansion, constant storage, padding and the final hash addition are left to the surrounding logic.

The block is chained by software or a sequencer. After two rounds, the new C, D, G and H equal the old A, B, E and F. So the A/B/E/F operand of one step is passed unchanged as the C/D/G/H operand of the next step, together with the returned result.

The handshake is valid/ready. With `REG_OUT = 1` (the default), a two-state controller holds the result. Its states are `ST_EMPTY` (no result held) and `ST_FULL` (a result is presented). `ST_EMPTY -> ST_FULL` happens on an accepted input. `ST_FULL -> ST_FULL` happens either on a stall (`out_ready` low) or on a drain with a simultaneous new accept. `ST_FULL -> ST_EMPTY` happens on a drain with no new input. With `REG_OUT = 0` the path is purely combinational and the handshake passes straight through.

Top module: `sha2r_unit`

## Requirements
- R1: `in_abef` carries A in bits 127:96, B in 95:64, E in 63:32 and F in 31:0. `in_cdgh` carries C in 127:96, D in 95:64, G in 63:32 and H in 31:0.
- R2: The first round uses `in_wk[31:0]` and the second round uses `in_wk[63:32]`. Bits 127:64 of `in_wk` have no effect on the result.
- R3: Each round forms T = H + Σ1(E) + Ch(E,F,G) + WK modulo 2^32, and the new A is T + Maj(A,B,C) + Σ0(A). Here Σ0 = ROTR2^ROTR13^ROTR22, Σ1 = ROTR6^ROTR11^ROTR25, Ch(x,y,z) = (x&y)^(~x&z) and Maj(x,y,z) = (x&y)^(x&z)^(y&z).
- R4: Each round sets the new E to T + D modulo 2^32. B, C and D take the old A, B and C. F, G and H take the old E, F and G.
- R5: Exactly two rounds are applied. `out_abef` packs A in 127:96, B in 95:64, E in 63:32 and F in 31:0.
- R6: Feeding a step's `in_abef` as the next step's `in_cdgh`, together with that step's result as `in_abef`, gives the same state as four consecutive rounds.
- R7: An input accepted (`in_valid && in_ready`) at a clock edge makes `out_valid` high from the next cycle on. A synchronous `rst` clears `out_valid`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_abef` hold their values and `in_ready` is low.
- R9: When the held result is taken (`out_ready` high) and no new input is accepted in that cycle, `out_valid` goes low in the next cycle. `in_ready` is high whenever no result is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present |
| in_ready | output | 1 | Operands can be accepted |
| in_cdgh | input | 128 | Packed C, D, G, H |
| in_abef | input | 128 | Packed A, B, E, F |
| in_wk | input | 128 | Message-plus-constant sums, low two words used |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_abef | output | 128 | Packed new A, B, E, F |

## Verification
The round function is tried with several patterns. An all-zero state with small WK values gives a hand-derived result that exposes any swap of word positions. The standard initial hash values check the real carry chains. All-ones words check the modulo-2^32 wraparound, and alternating bit patterns check the rotations. The same vector is then repeated with different upper WK bits, which separates a correct word select from one that reads the unused half. A chained pair of steps is compared against a four-round model. Stall, drain and reload sequences tell a correct hold apart from a result that is lost or repeated.

// File: rtl/sha2r_pkg.sv
package sha2r_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_ROUNDS = 2;
    localparam int PACK_W    = 4 * WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a; word_t b; word_t c; word_t d;
        word_t e; word_t f; word_t g; word_t h;
    } wstate_t;

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_sigma0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_sigma1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t choose(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic word_t majority(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

endpackage

// File: rtl/sha2r_round.sv
module sha2r_round
    import sha2r_pkg::*;
(
    input  wstate_t st_i,
    input  word_t   wk_i,
    output wstate_t st_o
);
    word_t t_shared;

    always_comb begin
        t_shared = st_i.h + big_sigma1(st_i.e) + choose(st_i.e, st_i.f, st_i.g) + wk_i;
        st_o.a = t_shared + majority(st_i.a, st_i.b, st_i.c) + big_sigma0(st_i.a);
        st_o.b = st_i.a;
        st_o.c = st_i.b;
        st_o.d = st_i.c;
        st_o.e = t_shared + st_i.d;
        st_o.f = st_i.e;
        st_o.g = st_i.f;
        st_o.h = st_i.g;
    end
endmodule

// File: rtl/sha2r_core.sv
module sha2r_core
    import sha2r_pkg::*;
(
    input  logic [PACK_W-1:0]          cdgh_i,
    input  logic [PACK_W-1:0]          abef_i,
    input  logic [NUM_ROUNDS*WORD_W-1:0] wk_i,
    output logic [PACK_W-1:0]          abef_o
);
    wstate_t chain [NUM_ROUNDS+1];

    always_comb begin
        chain[0].a = abef_i[4*WORD_W-1:3*WORD_W];
        chain[0].b = abef_i[3*WORD_W-1:2*WORD_W];
        chain[0].e = abef_i[2*WORD_W-1:WORD_W];
        chain[0].f = abef_i[WORD_W-1:0];
        chain[0].c = cdgh_i[4*WORD_W-1:3*WORD_W];
        chain[0].d = cdgh_i[3*WORD_W-1:2*WORD_W];
        chain[0].g = cdgh_i[2*WORD_W-1:WORD_W];
        chain[0].h = cdgh_i[WORD_W-1:0];
    end

    for (genvar r = 0; r < NUM_ROUNDS; r++) begin : g_round
        sha2r_round u_round (
            .st_i (chain[r]),
            .wk_i (wk_i[r*WORD_W +: WORD_W]),
            .st_o (chain[r+1])
        );
    end

    assign abef_o = {chain[NUM_ROUNDS].a, chain[NUM_ROUNDS].b,
                     chain[NUM_ROUNDS].e, chain[NUM_ROUNDS].f};

    logic unused_tail;
    assign unused_tail = ^{chain[NUM_ROUNDS].c, chain[NUM_ROUNDS].d,
                           chain[NUM_ROUNDS].g, chain[NUM_ROUNDS].h};
endmodule

// File: rtl/sha2r_outreg.sv
module sha2r_outreg #(
    parameter int DATA_W  = 128,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] d_i,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] q_o
);
    typedef enum logic {ST_EMPTY = 1'b0, ST_FULL = 1'b1} slot_e;

    if (REG_OUT) begin : g_reg
        slot_e             state_q, state_d;
        logic [DATA_W-1:0] data_q;
        logic              take;

        assign take = in_valid && in_ready;

        always_ff @(posedge clk) begin
            if (rst) state_q <= ST_EMPTY;
            else     state_q <= state_d;
        end

        always_ff @(posedge clk) begin
            if (take) data_q <= d_i;
        end

        always_comb begin
            state_d   = state_q;
            in_ready  = 1'b1;
            out_valid = 1'b0;
            unique case (state_q)
                ST_EMPTY: begin
                    if (take) state_d = ST_FULL;
                end
                ST_FULL: begin
                    out_valid = 1'b1;
                    in_ready  = out_ready;
                    if (out_ready && !take) state_d = ST_EMPTY;
                end
                default: state_d = ST_EMPTY;
            endcase
        end

        assign q_o = data_q;
    end else begin : g_pass
        assign in_ready  = out_ready;
        assign out_valid = in_valid;
        assign q_o       = d_i;
        logic unused_clk;
        assign unused_clk = clk ^ rst;
    end
endmodule

// File: rtl/sha2r_unit.sv
module sha2r_unit
    import sha2r_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [127:0] in_cdgh,
    input  logic [127:0] in_abef,
    input  logic [127:0] in_wk,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [127:0] out_abef
);
    localparam int WK_USED = NUM_ROUNDS * WORD_W;

    logic [PACK_W-1:0] result;

    sha2r_core u_core (
        .cdgh_i (in_cdgh),
        .abef_i (in_abef),
        .wk_i   (in_wk[WK_USED-1:0]),
        .abef_o (result)
    );

    sha2r_outreg #(.DATA_W(PACK_W), .REG_OUT(REG_OUT)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d_i       (result),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q_o       (out_abef)
    );

    logic unused_wk_hi;
    assign unused_wk_hi = ^in_wk[127:WK_USED];
endmodule

// File: rtl/sha2r_unit_chk.sv
module sha2r_unit_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [127:0] out_abef
);
    if (REG_OUT) begin : g_chk
        p_valid_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_ready) |=> out_valid);

        p_reset_clears_r7: assert property (@(posedge clk)
            rst |=> !out_valid);

        p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (rst)
            (out_valid && !out_ready) |=> (out_valid && $stable(out_abef)));

        p_no_accept_on_stall_r8: assert property (@(posedge clk) disable iff (rst)
            (out_valid && !out_ready) |-> !in_ready);

        p_drain_r9: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);

        p_ready_when_empty_r9: assert property (@(posedge clk) disable iff (rst)
            !out_valid |-> in_ready);
    end
endmodule

bind sha2r_unit sha2r_unit_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_abef  (out_abef)
);

// File: tb/sha2r_unit_test.sv
`timescale 1ns/1ps
module sha2r_unit_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid, in_ready, out_valid, out_ready;
    logic [127:0] in_cdgh, in_abef, in_wk, out_abef;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sha2r_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_cdgh(in_cdgh), .in_abef(in_abef), .in_wk(in_wk),
        .out_valid(out_valid), .out_ready(out_ready), .out_abef(out_abef)
    );

    // stimulus table: {cdgh, abef, wk}
    localparam logic [383:0] VECS [6] = '{
        {128'h0, 128'h0, 128'h0},
        {128'h3c6ef372_a54ff53a_1f83d9ab_5be0cd19, 128'h6a09e667_bb67ae85_510e527f_9b05688c,
         128'h0_0_71374491_428a2f98},
        {128'hffffffff_ffffffff_ffffffff_ffffffff, 128'hffffffff_ffffffff_ffffffff_ffffffff,
         128'h0_0_ffffffff_ffffffff},
        {128'haaaaaaaa_55555555_aaaaaaaa_55555555, 128'h55555555_aaaaaaaa_55555555_aaaaaaaa,
         128'h0_0_12345678_9abcdef0},
        {128'h80000000_00000001_80000000_00000001, 128'h00000001_80000000_00000001_80000000,
         128'h0_0_deadbeef_00c0ffee},
        {128'h01234567_89abcdef_fedcba98_76543210, 128'h0f0f0f0f_f0f0f0f0_33333333_cccccccc,
         128'h0_0_b5c0fbcf_e9b5dba5}
    };

    function automatic logic [31:0] m_rotr(input logic [31:0] x, input int n);
        logic [63:0] dbl;
        dbl = {x, x} >> n;
        return dbl[31:0];
    endfunction

    // software model of n rounds on eight words, wk words supplied low-first
    function automatic logic [255:0] model(input logic [255:0] st, input logic [127:0] wks, input int n);
        logic [31:0] a, b, c, d, e, f, g, h, t, s0, s1, ch, mj;
        {a, b, c, d, e, f, g, h} = st;
        for (int i = 0; i < n; i++) begin
            s1 = m_rotr(e, 6) ^ m_rotr(e, 11) ^ m_rotr(e, 25);
            s0 = m_rotr(a, 2) ^ m_rotr(a, 13) ^ m_rotr(a, 22);
            ch = (e & f) ^ (~e & g);
            mj = (a & b) ^ (a & c) ^ (b & c);
            t  = h + s1 + ch + wks[i*32 +: 32];
            h = g; g = f; f = e; e = d + t;
            d = c; c = b; b = a; a = t + s0 + mj;
        end
        return {a, b, c, d, e, f, g, h};
    endfunction

    function automatic logic [127:0] model2(input logic [127:0] cdgh, input logic [127:0] abef,
                                            input logic [127:0] wk);
        logic [255:0] r;
        r = model({abef[127:96], abef[95:64], cdgh[127:96], cdgh[95:64],
                   abef[63:32], abef[31:0], cdgh[63:32], cdgh[31:0]}, wk, 2);
        return {r[255:224], r[223:192], r[127:96], r[95:64]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // present one operand set for one accepted cycle, then sample result
    task automatic run_op(input logic [127:0] c, input logic [127:0] a, input logic [127:0] w,
                          output logic [127:0] res);
        @(negedge clk);
        in_cdgh = c; in_abef = a; in_wk = w; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        res = out_abef;
        check(out_valid == 1'b1, "R7 valid after accept", {127'b0, out_valid}, 128'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] res, res2, exp;
        logic [255:0] four;
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
        in_cdgh = '0; in_abef = '0; in_wk = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7 reset clears valid", {127'b0, out_valid}, 128'd0);
        check(in_ready == 1'b1, "R9 ready when empty", {127'b0, in_ready}, 128'd1);
        rst = 1'b0;

        // R3 R4 R5 table walk
        for (int i = 0; i < 6; i++) begin
            run_op(VECS[i][383:256], VECS[i][255:128], VECS[i][127:0], res);
            exp = model2(VECS[i][383:256], VECS[i][255:128], VECS[i][127:0]);
            check(res == exp, "R3/R4/R5 table vector", res, exp);
        end

        // R1 R5: hand-derived packing with zero state, wk0=1, wk1=0
        run_op(128'h0, 128'h0, 128'h0_0_00000000_00000001, res);
        exp = 128'h44280480_00000001_04200080_00000001;
        check(res == exp, "R1 R5 field positions", res, exp);

        // R1: only D set distinguishes cdgh word order
        run_op(128'h00000000_00000005_00000000_00000000, 128'h0, 128'h0, res);
        exp = model2(128'h00000000_00000005_00000000_00000000, 128'h0, 128'h0);
        check(res == exp, "R1 D lane", res, exp);

        // R2: upper wk bits have no effect
        run_op(VECS[1][383:256], VECS[1][255:128], {64'hffff0000_a5a5a5a5, VECS[1][63:0]}, res);
        exp = model2(VECS[1][383:256], VECS[1][255:128], VECS[1][127:0]);
        check(res == exp, "R2 upper wk ignored", res, exp);
        // R2: swapped wk words must change result
        run_op(128'h0, 128'h0, 128'h0_0_00000001_00000000, res);
        exp = model2(128'h0, 128'h0, 128'h0_0_00000001_00000000);
        check(res == exp && res != 128'h44280480_00000001_04200080_00000001,
              "R2 wk word order", res, exp);

        // R6: chaining two steps equals four rounds
        run_op(VECS[1][383:256], VECS[1][255:128], 128'h0_0_71374491_428a2f98, res);
        run_op(VECS[1][255:128], res, 128'h0_0_e9b5dba5_b5c0fbcf, res2);
        four = model({VECS[1][255:224], VECS[1][223:192], VECS[1][383:352], VECS[1][351:320],
                      VECS[1][191:160], VECS[1][159:128], VECS[1][319:288], VECS[1][287:256]},
                     128'h0_0_e9b5dba5_b5c0fbcf_71374491_428a2f98, 4);
        exp = {four[255:224], four[223:192], four[127:96], four[95:64]};
        check(res2 == exp, "R6 chained steps", res2, exp);

        // R9: drain with no new input drops valid
        @(negedge clk);
        check(out_valid == 1'b0, "R9 drop after drain", {127'b0, out_valid}, 128'd0);

        // R8: stall holds data and blocks input
        out_ready = 1'b0;
        @(negedge clk);
        in_cdgh = VECS[3][383:256]; in_abef = VECS[3][255:128]; in_wk = VECS[3][127:0]; in_valid = 1'b1;
        @(negedge clk);
        exp = model2(VECS[3][383:256], VECS[3][255:128], VECS[3][127:0]);
        in_cdgh = VECS[2][383:256]; in_abef = VECS[2][255:128]; in_wk = VECS[2][127:0];
        check(in_ready == 1'b0, "R8 ready low on stall", {127'b0, in_ready}, 128'd0);
        repeat (3) @(negedge clk);
        check(out_valid == 1'b1, "R8 valid held", {127'b0, out_valid}, 128'd1);
        check(out_abef == exp, "R8 data held", out_abef, exp);
        // release with new input waiting: reload next cycle
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        exp = model2(VECS[2][383:256], VECS[2][255:128], VECS[2][127:0]);
        check(out_valid == 1'b1 && out_abef == exp, "R8 reload after release", out_abef, exp);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 empty after last drain", {127'b0, out_valid}, 128'd0);

        // R7: reset while holding clears valid
        out_ready = 1'b0;
        run_op(VECS[0][383:256], VECS[0][255:128], VECS[0][127:0], res);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0, "R7 reset while full", {127'b0, out_valid}, 128'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule